// File: doc/BRIEF.md
# Fractional-Period Dithered Sample Timer

This block paces the sample updates of a slow waveform generator whose ideal sample period is not a whole number of clock ticks. A down-counting period timer is reloaded after every sample with either an integer length N or N+1. An 8-bit rolling accumulator gains a programmable fraction F once per sample, and its carry-out picks the longer length for the next sample. Over 256 samples exactly F of them are stretched by one tick. The average period is therefore N + F/256 ticks, and no single period departs from the ideal by more than one tick.

A sample index runs alongside the strobe and wraps modulo 180, so a downstream sine lookup of 180 points per waveform cycle can follow it directly. Software sets the integer period and the fraction. For example, with a tick of about 75 kHz and 180 samples per cycle, a 10 Hz output needs 41.667 ticks per sample, which is programmed as N = 41 and F = 171. Both settings pass through shadow registers and are used only at a sample boundary, so a change never splits a period.

Top module: `frac_sample_timer`

## Requirements
- R1: While reset is asserted and right after it, `strobe` is 0 and `sample_idx` is 0. Reset also clears the fraction accumulator to 0 and puts the period counter in its idle (load) state.
- R2: While `en` is 0, no strobe is issued and the counter, accumulator and index all hold. Sample timing counts only the cycles in which `en` is 1.
- R3: After reset, the first enabled cycle loads the counter, and the first strobe comes on the (Neff+1)-th enabled cycle.
- R4: The number of enabled cycles from strobe k to strobe k+1 (k = 1, 2, ...) is Neff + c_k, where c_k = floor(k·F/256) − floor((k−1)·F/256). This is the carry out of bit 7 when F is added to the 8-bit accumulator at strobe k.
- R5: `strobe` is high for exactly one clock per sample and is never high on two consecutive clocks.
- R6: Each strobe advances `sample_idx` by one, and 179 is followed by 0. During the k-th strobe cycle `sample_idx` reads (k−1) mod 180.
- R7: An integer period below 2 (the values 0 and 1) is treated as Neff = 2. Otherwise Neff = N.
- R8: `period_int` and `period_frac` are captured into shadow registers on every clock and are used only at a sample boundary. A value applied in the cycle of strobe k first sets the length of the period that follows strobe k+1.
- R9: Between strobes `sample_idx` holds its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Run enable; when low, all state holds |
| period_int | input | 16 | Integer sample period N in ticks |
| period_frac | input | 8 | Fractional period F in units of 1/256 tick |
| strobe | output | 1 | One-clock sample-update pulse |
| sample_idx | output | 8 | Sample index, 0 to 179 |

## Verification
The timer is run with fractions 0, 1, 128, 171 and 255. A zero fraction shows a plain fixed period. A fraction of 255 stretches nearly every sample, 128 alternates the two lengths, 1 stretches only once in 256 samples, and 171 produces the irregular pattern of a real setting. Every strobe time is compared against the closed-form carry sequence. Integer periods of 0 and 1 separate the clamp from a raw reload. A period change made mid-run shows whether the new value lands at the correct boundary. A gap in the enable shows whether disabled cycles are left out of the count. Runs of more than 180 samples cover the index wrap.

// File: rtl/fst_pkg.sv
package fst_pkg;
  localparam int unsigned CNT_W    = 16;
  localparam int unsigned FRAC_W   = 8;
  localparam int unsigned SAMPLES  = 180;
  localparam int unsigned IDX_W    = $clog2(SAMPLES);
  localparam int unsigned MIN_PER  = 2;

  // Raise an integer period to the minimum; result one bit wider so N+1 fits.
  function automatic logic [CNT_W:0] eff_period(input logic [CNT_W-1:0] n);
    logic [CNT_W:0] w;
    w = {1'b0, n};
    if (w < (CNT_W+1)'(MIN_PER)) w = (CNT_W+1)'(MIN_PER);
    return w;
  endfunction

  // Rolling fraction add: returns {carry, sum}.
  function automatic logic [FRAC_W:0] frac_add(input logic [FRAC_W-1:0] acc,
                                               input logic [FRAC_W-1:0] f);
    return {1'b0, acc} + {1'b0, f};
  endfunction

  // Modulo index step.
  function automatic logic [IDX_W-1:0] idx_step(input logic [IDX_W-1:0] i);
    return (i == IDX_W'(SAMPLES - 1)) ? '0 : i + 1'b1;
  endfunction
endpackage

// File: rtl/fst_shadow.sv
module fst_shadow #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  n_in,
  input  logic [FRAC_W-1:0] f_in,
  output logic [CNT_W-1:0]  n_sh,
  output logic [FRAC_W-1:0] f_sh
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      n_sh <= '0;
      f_sh <= '0;
    end else begin
      n_sh <= n_in;
      f_sh <= f_in;
    end
  end
endmodule

// File: rtl/fst_period_ctr.sv
module fst_period_ctr #(
  parameter int unsigned CW = 17
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [CW-1:0] start_len,
  input  logic [CW-1:0] reload_len,
  output logic          expire,
  output logic          start,
  output logic [CW-1:0] cnt_q
);
  logic idle;

  assign idle   = (cnt_q == '0);
  assign start  = en && idle;
  assign expire = en && (cnt_q == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (start) begin
      cnt_q <= start_len;
    end else if (expire) begin
      cnt_q <= reload_len;
    end else if (en) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/fst_frac_acc.sv
module fst_frac_acc #(
  parameter int unsigned FRAC_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              step,
  input  logic [FRAC_W-1:0] frac,
  output logic              carry,
  output logic [FRAC_W-1:0] acc_q
);
  logic [FRAC_W:0] sum;

  assign sum   = fst_pkg::frac_add(acc_q, frac);
  assign carry = sum[FRAC_W];

  always_ff @(posedge clk) begin
    if (!rst_n)    acc_q <= '0;
    else if (step) acc_q <= sum[FRAC_W-1:0];
  end
endmodule

// File: rtl/fst_idx_ctr.sv
module fst_idx_ctr #(
  parameter int unsigned IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  output logic [IDX_W-1:0] idx_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)    idx_q <= '0;
    else if (step) idx_q <= fst_pkg::idx_step(idx_q);
  end
endmodule

// File: rtl/frac_sample_timer.sv
module frac_sample_timer #(
  parameter int unsigned CNT_W  = fst_pkg::CNT_W,
  parameter int unsigned FRAC_W = fst_pkg::FRAC_W,
  parameter int unsigned IDX_W  = fst_pkg::IDX_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [CNT_W-1:0]  period_int,
  input  logic [FRAC_W-1:0] period_frac,
  output logic              strobe,
  output logic [IDX_W-1:0]  sample_idx
);
  localparam int unsigned CW = CNT_W + 1;

  logic [CNT_W-1:0]  n_sh;
  logic [FRAC_W-1:0] f_sh;
  logic [CW-1:0]     base_len;
  logic [CW-1:0]     reload_len;
  logic [CW-1:0]     cnt_q;
  logic [FRAC_W-1:0] acc_q;
  logic              carry;
  logic              expire_evt;
  logic              load_evt;

  fst_shadow #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_shadow (
    .clk(clk), .rst_n(rst_n), .n_in(period_int), .f_in(period_frac),
    .n_sh(n_sh), .f_sh(f_sh)
  );

  assign base_len   = fst_pkg::eff_period(n_sh);
  assign reload_len = base_len + CW'(carry);

  fst_period_ctr #(.CW(CW)) u_ctr (
    .clk(clk), .rst_n(rst_n), .en(en),
    .start_len(base_len), .reload_len(reload_len),
    .expire(expire_evt), .start(load_evt), .cnt_q(cnt_q)
  );

  fst_frac_acc #(.FRAC_W(FRAC_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .step(expire_evt), .frac(f_sh),
    .carry(carry), .acc_q(acc_q)
  );

  fst_idx_ctr #(.IDX_W(IDX_W)) u_idx (
    .clk(clk), .rst_n(rst_n), .step(expire_evt), .idx_q(sample_idx)
  );

  assign strobe = expire_evt;
endmodule

// File: rtl/fst_checker.sv
module fst_checker #(
  parameter int unsigned IDX_W   = 8,
  parameter int unsigned CW      = 17,
  parameter int unsigned FRAC_W  = 8,
  parameter int unsigned SAMPLES = 180
) (
  input logic              clk,
  input logic              rst_n,
  input logic              en,
  input logic              strobe,
  input logic [IDX_W-1:0]  sample_idx,
  input logic [CW-1:0]     cnt_q,
  input logic [FRAC_W-1:0] acc_q,
  input logic              load_evt
);
  a_r2_no_strobe_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> !strobe);
  a_r2_hold_counter: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(cnt_q) && $stable(acc_q));
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> !strobe);
  a_r6_idx_advance: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |=> sample_idx == (($past(sample_idx) == IDX_W'(SAMPLES-1)) ?
                              '0 : $past(sample_idx) + 1'b1));
  a_r6_idx_range: assert property (@(posedge clk) disable iff (!rst_n)
    sample_idx < IDX_W'(SAMPLES));
  a_r9_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !strobe |=> $stable(sample_idx));
  a_r7_min_period: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> cnt_q >= CW'(2));
  a_r3_load_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |-> !strobe);
endmodule

bind frac_sample_timer fst_checker #(
  .IDX_W(IDX_W), .CW(CW), .FRAC_W(FRAC_W), .SAMPLES(fst_pkg::SAMPLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .strobe(strobe),
  .sample_idx(sample_idx), .cnt_q(cnt_q), .acc_q(acc_q), .load_evt(load_evt)
);

// File: tb/frac_sample_timer_tb.sv
module frac_sample_timer_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NSAMP      = 180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        en = 1'b0;
  logic [15:0] period_int = '0;
  logic [7:0]  period_frac = '0;
  logic        strobe;
  logic [7:0]  sample_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_sample_timer dut_i (
    .clk(clk), .rst_n(rst_n), .en(en), .period_int(period_int),
    .period_frac(period_frac), .strobe(strobe), .sample_idx(sample_idx)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int neff(input int n);
    return (n < 2) ? 2 : n;
  endfunction

  function automatic int cbit(input int k, input int f);
    return (k * f) / 256 - ((k - 1) * f) / 256;
  endfunction

  // Run one configuration from reset; optional period change and enable gap.
  task automatic run(input int n, input int f, input int nstr,
                     input int chg_k, input int n2,
                     input int gap_k, input int gap_len);
    int e = 0;
    int k = 0;
    int nexp;
    int guard = 0;
    bit prev_s = 1'b0;
    bit gap_pend = 1'b0;
    @(negedge clk);
    rst_n = 1'b0; en = 1'b0;
    period_int = 16'(n); period_frac = 8'(f);
    repeat (2) @(negedge clk);
    check(strobe == 1'b0, "R1 strobe in reset", int'(strobe), 0);
    check(sample_idx == 8'd0, "R1 idx in reset", int'(sample_idx), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(strobe == 1'b0 && sample_idx == 8'd0, "R1 after reset",
          int'(sample_idx), 0);
    nexp = neff(n) + 1;                    // R3 first strobe
    en = 1'b1;
    while (k < nstr && guard < 100000) begin
      guard++;
      if (gap_pend) begin
        gap_pend = 1'b0;
        en = 1'b0;
        for (int g = 0; g < gap_len; g++) begin
          @(negedge clk);
          check(strobe == 1'b0, "R2 strobe while disabled", int'(strobe), 0);
          check(int'(sample_idx) == k % NSAMP, "R2 idx while disabled",
                int'(sample_idx), k % NSAMP);
        end
        en = 1'b1;
      end
      e++;
      if (strobe) begin
        k++;
        check(!prev_s, "R5 back-to-back strobe", 1, 0);
        check(e == nexp, (k == 1) ? "R3 first strobe time" : "R4 strobe time",
              e, nexp);
        check(int'(sample_idx) == (k - 1) % NSAMP, "R6 index at strobe",
              int'(sample_idx), (k - 1) % NSAMP);
        nexp = e + neff((chg_k > 0 && k > chg_k) ? n2 : n) + cbit(k, f);
        if (k == chg_k) period_int = 16'(n2);   // R8 shadow boundary
        if (k == gap_k) gap_pend = 1'b1;
      end else if (k > 0) begin
        check(int'(sample_idx) == k % NSAMP, "R9 idx hold", int'(sample_idx),
              k % NSAMP);
      end
      prev_s = strobe;
      @(negedge clk);
    end
    check(k == nstr, "R4 strobe count", k, nstr);
  endtask

  initial begin : watchdog
    while (cyc < 190000) begin
      @(posedge clk);
      cyc++;
    end
    checks++; fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : main
    run(41, 171, 200, 0, 0, 0, 0);    // R4 R6: real setting, index wrap
    run(3, 0, 20, 0, 0, 0, 0);        // R4: plain period
    run(3, 255, 40, 0, 0, 0, 0);      // R4: nearly all stretched
    run(5, 1, 260, 0, 0, 0, 0);       // R4: one carry in 256
    run(0, 128, 30, 0, 0, 0, 0);      // R7: zero clamps to 2
    run(1, 0, 20, 0, 0, 0, 0);        // R7: one clamps to 2
    run(4, 0, 12, 3, 7, 0, 0);        // R8: period change at boundary
    run(6, 128, 12, 0, 0, 2, 9);      // R2: enable gap
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule